// File: doc/BRIEF.md
# Inter-Controller Interrupt Mailbox and Shared Grader

This block lets several controllers that share one crate send messages and raise interrupts on one another. It holds one 24-bit mailbox word for each controller. Whoever currently owns the bus may read or write any mailbox. It also holds a lock register. A write to the lock register raises or drops a mailbox interrupt request aimed at one chosen controller. A sender normally writes the message word into the target's mailbox first and then writes the lock register. When the target reads its own mailbox, its pending request clears by itself.

A single grader is shared by all controllers. It sees the module interrupt request lines and the per-controller mailbox requests. Each controller owns a mask. From it the grader derives that controller's interrupt line and the number of its highest-priority pending source. The register bus is a plain address, data, write and read interface. It also carries the ID of the controller that currently owns the bus.

Top module: `lm_mailbox_unit`

## Requirements
- R1: After a synchronous reset, every mailbox word, every mask and every pending mailbox request is zero, and every interrupt line and source number is zero.
- R2: Mailbox k sits at address k (k below NCTRL). Any bus ID may write it or read it. Read data is registered: it appears on `bus_rdata` after the clock edge that samples `bus_rd`, and it holds until the next read.
- R3: A write to the lock register (address 0x10) with data bit 3 set raises the pending mailbox request of the controller selected by data bits 2:0.
- R4: A lock register write with data bit 3 clear drops the pending request of the selected controller. Requests of other controllers are unchanged.
- R5: When controller k reads mailbox k, its own pending request clears on that edge. A read of mailbox k by any other ID leaves the request pending.
- R6: Controller k's mask sits at address 0x20+k, in bits 16:0. It changes only when the bus ID equals k. A write to it carrying any other ID is ignored.
- R7: The source numbering is as follows: module request j is source j (0 to 15), and the controller's own mailbox request is source 16. A mask bit set to 1 enables the source. Controller k's interrupt line is high exactly when at least one enabled source is pending. The line follows the module request inputs with no clock delay.
- R8: A controller's 5-bit source number, at bits 5k+4:5k of `irq_src`, gives the lowest-numbered enabled pending source. It is 0 when none is pending.
- R9: The interrupt view of each controller depends only on its own mask and its own mailbox request. The same module requests can produce different lines and source numbers for different controllers.
- R10: Reading the lock register returns the pending request vector, with bit k for controller k. Reading a mask returns that mask. Reading an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register address |
| bus_wdata | input | 24 | Write data |
| bus_id | input | 3 | ID of the controller that owns the bus |
| bus_rdata | output | 24 | Registered read data |
| mod_lam | input | 16 | Module interrupt request lines |
| irq | output | 8 | Interrupt line for each controller |
| irq_src | output | 40 | Packed 5-bit source number for each controller |

## Verification
On every cycle the assertions check how lock writes and owner reads move each pending mailbox request. They also check that a mask write carrying a foreign ID leaves the mask unchanged, that an asserted interrupt always names a source that is both pending and enabled, and that an all-zero mask keeps a line low. Only the bench scenarios can show the following: mailbox data surviving a round trip, read data arriving one edge late, the lowest-number rule when several sources compete, and two controllers holding different views of the same module requests.

// File: rtl/lmbx_pkg.sv
package lmbx_pkg;

    // Address map of the register bus
    localparam int MBOX_BASE    = 0;
    localparam int LOCK_ADDR    = 16;
    localparam int MASK_BASE    = 32;

    // Lock register: low bits pick the target, this bit sets or clears
    localparam int LOCK_SET_BIT = 3;

    // Limit of the shared priority search
    localparam int SCAN_W       = 32;
    localparam int SCAN_PW      = $clog2(SCAN_W);

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MBOX,
        SEL_LOCK,
        SEL_MASK
    } reg_sel_e;

    typedef struct packed {
        logic               hit;
        logic [SCAN_PW-1:0] pos;
    } first_t;

    // Lowest set bit of a request vector
    function automatic first_t first_set(input logic [SCAN_W-1:0] v);
        first_t r;
        r.hit = 1'b0;
        r.pos = '0;
        for (int i = SCAN_W - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.pos = SCAN_PW'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lm_decode.sv
module lm_decode
    import lmbx_pkg::*;
#(
    parameter int NCTRL = 8,
    parameter int AW    = 6,
    localparam int IDW  = $clog2(NCTRL)
) (
    input  logic [AW-1:0]  addr,
    output reg_sel_e       sel,
    output logic [IDW-1:0] idx
);

    localparam logic [AW-1:0] MBOX_LO = AW'(MBOX_BASE);
    localparam logic [AW-1:0] MASK_LO = AW'(MASK_BASE);
    localparam logic [AW-1:0] LOCK_A  = AW'(LOCK_ADDR);
    localparam logic [AW-1:0] SPAN    = AW'(NCTRL);

    logic [AW-1:0] off_mbox;
    logic [AW-1:0] off_mask;

    assign off_mbox = addr - MBOX_LO;
    assign off_mask = addr - MASK_LO;

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (off_mbox < SPAN) begin
            sel = SEL_MBOX;
            idx = off_mbox[IDW-1:0];
        end else if (addr == LOCK_A) begin
            sel = SEL_LOCK;
        end else if (off_mask < SPAN) begin
            sel = SEL_MASK;
            idx = off_mask[IDW-1:0];
        end
    end

endmodule

// File: rtl/lm_mailbox.sv
module lm_mailbox #(
    parameter int NCTRL = 8,
    parameter int DW    = 24,
    localparam int IDW  = $clog2(NCTRL)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IDW-1:0]             idx,
    input  logic [DW-1:0]              wdata,
    output logic [NCTRL-1:0][DW-1:0]   words
);

    for (genvar k = 0; k < NCTRL; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[k] <= '0;
            end else if (we && idx == IDW'(k)) begin
                words[k] <= wdata;
            end
        end
    end

endmodule

// File: rtl/lm_lockreg.sv
module lm_lockreg #(
    parameter int NCTRL = 8,
    localparam int IDW  = $clog2(NCTRL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock_we,
    input  logic [IDW-1:0]   lock_tgt,
    input  logic             lock_set,
    input  logic             mbox_rd,
    input  logic [IDW-1:0]   rd_idx,
    input  logic [IDW-1:0]   rd_id,
    output logic [NCTRL-1:0] pend
);

    for (genvar k = 0; k < NCTRL; k++) begin : g_pend
        logic hit_lock;
        logic own_read;

        assign hit_lock = lock_we && (lock_tgt == IDW'(k));
        assign own_read = mbox_rd && (rd_idx == IDW'(k)) && (rd_id == IDW'(k));

        // A lock write beats a simultaneous owner read
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[k] <= 1'b0;
            end else if (hit_lock) begin
                pend[k] <= lock_set;
            end else if (own_read) begin
                pend[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lm_maskbank.sv
module lm_maskbank #(
    parameter int NCTRL = 8,
    parameter int NSRC  = 17,
    localparam int IDW  = $clog2(NCTRL)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [IDW-1:0]              idx,
    input  logic [IDW-1:0]              id,
    input  logic [NSRC-1:0]             wdata,
    output logic [NCTRL-1:0][NSRC-1:0]  masks
);

    for (genvar k = 0; k < NCTRL; k++) begin : g_mask
        logic owner_wr;

        assign owner_wr = we && (idx == IDW'(k)) && (id == IDW'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                masks[k] <= '0;
            end else if (owner_wr) begin
                masks[k] <= wdata;
            end
        end
    end

endmodule

// File: rtl/lm_grader.sv
module lm_grader
    import lmbx_pkg::*;
#(
    parameter int NCTRL = 8,
    parameter int NMOD  = 16,
    localparam int NSRC = NMOD + 1,
    localparam int SRCW = $clog2(NSRC)
) (
    input  logic [NMOD-1:0]             mod_lam,
    input  logic [NCTRL-1:0]            pend,
    input  logic [NCTRL-1:0][NSRC-1:0]  masks,
    output logic [NCTRL-1:0]            irq,
    output logic [NCTRL*SRCW-1:0]       irq_src
);

    for (genvar c = 0; c < NCTRL; c++) begin : g_view
        logic [NSRC-1:0] live;
        first_t          top;

        assign live = {pend[c], mod_lam} & masks[c];
        assign top  = first_set(SCAN_W'(live));

        assign irq[c]                   = top.hit;
        assign irq_src[c*SRCW +: SRCW]  = SRCW'(top.pos);
    end

endmodule

// File: rtl/lm_mailbox_unit.sv
module lm_mailbox_unit
    import lmbx_pkg::*;
#(
    parameter int NCTRL = 8,
    parameter int NMOD  = 16,
    parameter int DW    = 24,
    parameter int AW    = 6,
    localparam int IDW  = $clog2(NCTRL),
    localparam int NSRC = NMOD + 1,
    localparam int SRCW = $clog2(NSRC)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [AW-1:0]         bus_addr,
    input  logic [DW-1:0]         bus_wdata,
    input  logic [IDW-1:0]        bus_id,
    output logic [DW-1:0]         bus_rdata,
    input  logic [NMOD-1:0]       mod_lam,
    output logic [NCTRL-1:0]      irq,
    output logic [NCTRL*SRCW-1:0] irq_src
);

    reg_sel_e                   sel;
    logic [IDW-1:0]             idx;
    logic                       mbox_we;
    logic                       mbox_rd;
    logic                       lock_we;
    logic                       mask_we;
    logic [NCTRL-1:0][DW-1:0]   mbox_q;
    logic [NCTRL-1:0]           lam_pend;
    logic [NCTRL-1:0][NSRC-1:0] ctrl_mask;

    lm_decode #(.NCTRL(NCTRL), .AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    assign mbox_we = bus_wr && (sel == SEL_MBOX);
    assign mbox_rd = bus_rd && (sel == SEL_MBOX);
    assign lock_we = bus_wr && (sel == SEL_LOCK);
    assign mask_we = bus_wr && (sel == SEL_MASK);

    lm_mailbox #(.NCTRL(NCTRL), .DW(DW)) u_mbox (
        .clk   (clk),
        .rst   (rst),
        .we    (mbox_we),
        .idx   (idx),
        .wdata (bus_wdata),
        .words (mbox_q)
    );

    lm_lockreg #(.NCTRL(NCTRL)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .lock_we  (lock_we),
        .lock_tgt (bus_wdata[IDW-1:0]),
        .lock_set (bus_wdata[LOCK_SET_BIT]),
        .mbox_rd  (mbox_rd),
        .rd_idx   (idx),
        .rd_id    (bus_id),
        .pend     (lam_pend)
    );

    lm_maskbank #(.NCTRL(NCTRL), .NSRC(NSRC)) u_mask (
        .clk   (clk),
        .rst   (rst),
        .we    (mask_we),
        .idx   (idx),
        .id    (bus_id),
        .wdata (bus_wdata[NSRC-1:0]),
        .masks (ctrl_mask)
    );

    lm_grader #(.NCTRL(NCTRL), .NMOD(NMOD)) u_grade (
        .mod_lam (mod_lam),
        .pend    (lam_pend),
        .masks   (ctrl_mask),
        .irq     (irq),
        .irq_src (irq_src)
    );

    // Registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (sel)
                SEL_MBOX: bus_rdata <= mbox_q[idx];
                SEL_LOCK: bus_rdata <= DW'(lam_pend);
                SEL_MASK: bus_rdata <= DW'(ctrl_mask[idx]);
                default:  bus_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/lm_mailbox_chk.sv
module lm_mailbox_chk
    import lmbx_pkg::*;
#(
    parameter int NCTRL = 8,
    parameter int NMOD  = 16,
    parameter int AW    = 6,
    localparam int IDW  = $clog2(NCTRL),
    localparam int NSRC = NMOD + 1,
    localparam int SRCW = $clog2(NSRC)
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [AW-1:0]              bus_addr,
    input logic [IDW-1:0]             lock_tgt,
    input logic                       lock_set,
    input logic [IDW-1:0]             bus_id,
    input logic [NMOD-1:0]            mod_lam,
    input logic [NCTRL-1:0]           pend,
    input logic [NCTRL-1:0][NSRC-1:0] masks,
    input logic [NCTRL-1:0]           irq,
    input logic [NCTRL*SRCW-1:0]      irq_src
);

    localparam logic [AW-1:0] LOCK_A = AW'(LOCK_ADDR);

    logic lock_wr;
    assign lock_wr = bus_wr && (bus_addr == LOCK_A);

    for (genvar k = 0; k < NCTRL; k++) begin : g_k
        logic [NSRC-1:0] avail;
        logic [SRCW-1:0] num;

        assign avail = {pend[k], mod_lam} & masks[k];
        assign num   = irq_src[k*SRCW +: SRCW];

        AST_LOCK_RAISE: assert property (@(posedge clk) disable iff (rst)
            (lock_wr && lock_set && lock_tgt == IDW'(k)) |=> pend[k]);            // R3

        AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
            (lock_wr && !lock_set && lock_tgt == IDW'(k)) |=> !pend[k]);          // R4

        AST_OWNER_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (bus_rd && bus_addr == AW'(MBOX_BASE + k) && bus_id == IDW'(k)
             && !(lock_wr && lock_tgt == IDW'(k))) |=> !pend[k]);                  // R5

        AST_FOREIGN_MASK_IGNORED: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == AW'(MASK_BASE + k) && bus_id != IDW'(k))
            |=> $stable(masks[k]));                                                // R6

        AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (rst)
            (masks[k] == '0) |-> !irq[k]);                                         // R7

        AST_SRC_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
            irq[k] |-> (num < SRCW'(NSRC) && avail[num]));                         // R8
    end

endmodule

bind lm_mailbox_unit lm_mailbox_chk #(
    .NCTRL (NCTRL),
    .NMOD  (NMOD),
    .AW    (AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .lock_tgt (bus_wdata[IDW-1:0]),
    .lock_set (bus_wdata[lmbx_pkg::LOCK_SET_BIT]),
    .bus_id   (bus_id),
    .mod_lam  (mod_lam),
    .pend     (lam_pend),
    .masks    (ctrl_mask),
    .irq      (irq),
    .irq_src  (irq_src)
);

// File: tb/sim_lm_mailbox_unit.sv
module sim_lm_mailbox_unit;

    localparam int CLK_P = 10;
    localparam int NC    = 8;
    localparam int NM    = 16;
    localparam int SW    = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [23:0]   bus_wdata = '0;
    logic [2:0]    bus_id = '0;
    logic [23:0]   bus_rdata;
    logic [NM-1:0] mod_lam = '0;
    logic [NC-1:0] irq;
    logic [NC*SW-1:0] irq_src;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    lm_mailbox_unit u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_id(bus_id),
        .bus_rdata(bus_rdata), .mod_lam(mod_lam), .irq(irq), .irq_src(irq_src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [23:0] d, input logic [2:0] id);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_id = id;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [2:0] id, output logic [23:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_id = id;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    function automatic logic [4:0] src_of(input int c);
        return irq_src[c*SW +: SW];
    endfunction

    // Independent model of one controller's view
    function automatic logic [5:0] view(input logic [15:0] m, input logic p, input logic [16:0] mk);
        logic [16:0] v;
        v = {p, m} & mk;
        for (int i = 0; i < 17; i++)
            if (v[i]) return {1'b1, 5'(i)};
        return 6'd0;
    endfunction

    task automatic t_reset();
        logic [23:0] d;
        chk("R1 irq after reset", 32'(irq), 0);
        chk("R1 irq_src after reset", irq_src[31:0], 0);
        rd(6'd3, 3'd0, d);   chk("R1 mailbox 3 zero", 32'(d), 0);
        rd(6'h24, 3'd4, d);  chk("R1 mask 4 zero", 32'(d), 0);
        rd(6'h10, 3'd1, d);  chk("R1 pending zero", 32'(d), 0);
    endtask

    task automatic t_mailbox();
        logic [23:0] d;
        wr(6'd5, 24'hABCDEF, 3'd2);
        wr(6'd0, 24'h123456, 3'd7);
        rd(6'd5, 3'd6, d);   chk("R2 mailbox 5 read by other ID", 32'(d), 32'hABCDEF);
        rd(6'd0, 3'd1, d);   chk("R2 mailbox 0", 32'(d), 32'h123456);
        // Data holds after the read strobe drops
        @(negedge clk);      chk("R2 rdata holds", 32'(bus_rdata), 32'h123456);
        rd(6'h3F, 3'd0, d);  chk("R10 unmapped reads zero", 32'(d), 0);
        rd(6'h11, 3'd0, d);  chk("R10 address next to lock reads zero", 32'(d), 0);
    endtask

    task automatic t_mask_owner();
        logic [23:0] d;
        wr(6'h23, 24'h01FFFF, 3'd3);
        rd(6'h23, 3'd0, d);  chk("R6 R10 owner mask write", 32'(d), 32'h1FFFF);
        wr(6'h23, 24'h000000, 3'd1);
        rd(6'h23, 3'd0, d);  chk("R6 foreign mask write ignored", 32'(d), 32'h1FFFF);
        @(negedge clk);      chk("R6 ctrl 3 quiet", 32'(irq[3]), 0);
    endtask

    task automatic t_lock();
        logic [23:0] d;
        wr(6'h10, 24'h00000B, 3'd0);
        rd(6'h10, 3'd0, d);  chk("R3 R10 pending vector", 32'(d), 32'h08);
        chk("R3 R7 ctrl 3 irq on mailbox", 32'(irq[3]), 1);
        chk("R7 mailbox source is 16", 32'(src_of(3)), 16);
        rd(6'd3, 3'd1, d);   @(negedge clk);
        chk("R5 foreign read keeps request", 32'(irq[3]), 1);
        rd(6'd3, 3'd3, d);   @(negedge clk);
        chk("R5 owner read clears request", 32'(irq[3]), 0);
        rd(6'h10, 3'd0, d);  chk("R5 pending vector empty", 32'(d), 0);
        wr(6'h10, 24'h00000B, 3'd4);
        wr(6'h10, 24'h00000D, 3'd4);
        wr(6'h10, 24'h000003, 3'd4);
        rd(6'h10, 3'd0, d);  chk("R4 clear drops only target", 32'(d), 32'h20);
        wr(6'h10, 24'h000005, 3'd0);
    endtask

    task automatic t_grader();
        logic [23:0] d;
        logic [5:0]  e;
        wr(6'h25, 24'h000210, 3'd5);
        mod_lam = 16'h0208;
        @(negedge clk);
        e = view(16'h0208, 1'b0, 17'h1FFFF);
        chk("R8 ctrl 3 lowest source", 32'(src_of(3)), 32'(e[4:0]));
        e = view(16'h0208, 1'b0, 17'h00210);
        chk("R9 ctrl 5 own view", 32'(src_of(5)), 32'(e[4:0]));
        chk("R9 irq vector", 32'(irq), 32'h28);
        chk("R8 unmasked ctrl source zero", 32'(src_of(0)), 0);
        mod_lam = 16'h0010;
        @(negedge clk);
        chk("R7 ctrl 5 source 4", 32'(src_of(5)), 4);
        mod_lam = 16'h0000;
        @(negedge clk);
        chk("R7 no requests no irq", 32'(irq), 0);
        chk("R8 idle source zero", 32'(src_of(3)), 0);
        wr(6'h10, 24'h00000B, 3'd2);
        mod_lam = 16'h8000;
        @(negedge clk);
        chk("R8 module 15 beats mailbox", 32'(src_of(3)), 15);
        chk("R9 ctrl 5 ignores disabled", 32'(irq[5]), 0);
        mod_lam = 16'h0000;
        rd(6'd3, 3'd3, d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mailbox();
        t_mask_owner();
        t_lock();
        t_grader();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule